// File: doc/BRIEF.md
# Pipeline Advance and Occupancy Controller

This block decides, every cycle, which stages of a six-stage in-order processor pipeline may take new contents and which stages currently hold a live instruction. Stage index 0 is Fetch, then Decode, Execute, Memory, Align, and index 5 is Writeback. Two stages may ask for a hold: Decode, when an operand depends on a long-latency result (load, multiply, shift) that is not yet ready, and Align, when a memory access is waiting on the bus or a multi-cycle unit (shift/rotate, divide, custom operation) is still busy. A hold freezes the requesting stage and everything ahead of it in the fetch direction, with no attempt to close up empty slots.

The surrounding datapath uses `adv_o` as its per-stage register enables and `valid_o` as the occupancy of each stage. A front-end flush (for example after a mispredicted branch) discards whatever sits in Fetch and Decode. `retire_o` marks the cycle in which the instruction in Writeback completes.

Top module: `psc_pipe_ctl`

## Requirements
- R1: A synchronous active-high reset clears every bit of `valid_o` and `retire_o` at the next rising edge.
- R2: With no hold and no flush, each valid bit moves one stage per cycle: `fetch_valid_i` enters bit 0 (Fetch) and bit k takes the old bit k-1; an instruction presented at an edge appears on `retire_o` after the sixth rising edge.
- R3: Bit k of `adv_o` and `valid_o` refers to stage k, with 0 = Fetch, 1 = Decode, 2 = Execute, 3 = Memory, 4 = Align, 5 = Writeback; `adv_o[k]` is 1 exactly when stage k is not frozen this cycle.
- R4: While `aln_stall_i` is high, `adv_o[4:0]` is 0 and valid bits 0 to 4 keep their values at the edge, including empty slots; a new fetch is not taken.
- R5: While `aln_stall_i` is high, Writeback still advances and its valid bit is cleared at the edge, so no instruction retires twice.
- R6: When only `dec_stall_i` is high, `adv_o` is 6'b111100, Fetch and Decode keep their valid bits, a bubble (0) enters Execute, and bits 3 to 5 take the old bits 2 to 4.
- R7: When both hold requests are high, the Align hold governs: the result equals R4 and R5.
- R8: `flush_i` clears valid bits 0 and 1 at the next edge and overrides any hold on them; stages 2 to 5 behave as they would without the flush.
- R9: `adv_o[5]` (Writeback) is 1 in every cycle; `retire_o` equals the Writeback valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid_i | input | 1 | A new instruction is offered to Fetch this cycle |
| dec_stall_i | input | 1 | Hold request from Decode (operand dependency) |
| aln_stall_i | input | 1 | Hold request from Align (bus wait or busy unit) |
| flush_i | input | 1 | Discard the contents of Fetch and Decode |
| adv_o | output | 6 | Per-stage advance enable, bit 0 = Fetch |
| valid_o | output | 6 | Per-stage occupancy, bit 0 = Fetch |
| retire_o | output | 1 | Instruction in Writeback completes this cycle |

## Verification
The assertions watch, on every cycle, the relation between the hold and flush inputs and the next occupancy vector: plain shifting when nothing holds, the frozen prefix under an Align hold, the Execute bubble under a Decode hold, the drained Writeback slot, the cleared front end after a flush, and the ever-advancing last stage. What only the directed scenarios show is that whole occupancy patterns with gaps survive a hold unchanged and then resume in order, that the flush wins against both kinds of hold in the same cycle, and that the retire pulses come out in the order instructions were fetched.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
  typedef enum logic [2:0] {
    STG_FETCH  = 3'd0,
    STG_DECODE = 3'd1,
    STG_EXEC   = 3'd2,
    STG_MEM    = 3'd3,
    STG_ALIGN  = 3'd4,
    STG_WB     = 3'd5
  } stage_e;

  localparam int unsigned PSC_STAGES      = 6;
  localparam int unsigned PSC_DEC_IDX     = int'(STG_DECODE);
  localparam int unsigned PSC_ALN_IDX     = int'(STG_ALIGN);
  localparam int unsigned PSC_FLUSH_DEPTH = 2;
endpackage

// File: rtl/psc_hold_mask.sv
`timescale 1ns/1ps
module psc_hold_mask #(
  parameter int unsigned N_STG   = 6,
  parameter int unsigned DEC_IDX = 1,
  parameter int unsigned ALN_IDX = 4
) (
  input  logic             dec_req_i,
  input  logic             aln_req_i,
  output logic [N_STG-1:0] hold_o
);
  // A request freezes its own stage and every stage before it.
  for (genvar k = 0; k < N_STG; k++) begin : g_mask
    logic by_dec;
    logic by_aln;
    if (k <= DEC_IDX) begin : g_d
      assign by_dec = dec_req_i;
    end else begin : g_nd
      assign by_dec = 1'b0;
    end
    if (k <= ALN_IDX) begin : g_a
      assign by_aln = aln_req_i;
    end else begin : g_na
      assign by_aln = 1'b0;
    end
    assign hold_o[k] = by_dec | by_aln;
  end
endmodule

// File: rtl/psc_valid_stage.sv
`timescale 1ns/1ps
module psc_valid_stage #(
  parameter bit KILLABLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic kill_i,
  input  logic hold_self_i,
  input  logic hold_prev_i,
  input  logic prev_valid_i,
  output logic valid_o
);
  logic kill_eff;
  assign kill_eff = KILLABLE & kill_i;

  always_ff @(posedge clk) begin
    if (rst)              valid_o <= 1'b0;
    else if (kill_eff)    valid_o <= 1'b0;
    else if (hold_self_i) valid_o <= valid_o;
    else if (hold_prev_i) valid_o <= 1'b0;   // upstream frozen: bubble
    else                  valid_o <= prev_valid_i;
  end
endmodule

// File: rtl/psc_pipe_ctl.sv
`timescale 1ns/1ps
module psc_pipe_ctl
  import psc_pkg::*;
#(
  parameter int unsigned N_STG       = PSC_STAGES,
  parameter int unsigned DEC_IDX     = PSC_DEC_IDX,
  parameter int unsigned ALN_IDX     = PSC_ALN_IDX,
  parameter int unsigned FLUSH_DEPTH = PSC_FLUSH_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid_i,
  input  logic             dec_stall_i,
  input  logic             aln_stall_i,
  input  logic             flush_i,
  output logic [N_STG-1:0] adv_o,
  output logic [N_STG-1:0] valid_o,
  output logic             retire_o
);
  localparam int unsigned LAST = N_STG - 1;

  logic [N_STG-1:0] hold;

  psc_hold_mask #(
    .N_STG  (N_STG),
    .DEC_IDX(DEC_IDX),
    .ALN_IDX(ALN_IDX)
  ) u_mask (
    .dec_req_i(dec_stall_i),
    .aln_req_i(aln_stall_i),
    .hold_o   (hold)
  );

  assign adv_o = ~hold;

  for (genvar k = 0; k < N_STG; k++) begin : g_stage
    logic prev_v;
    logic prev_h;
    if (k == 0) begin : g_head
      assign prev_v = fetch_valid_i;
      assign prev_h = 1'b0;
    end else begin : g_body
      assign prev_v = valid_o[k-1];
      assign prev_h = hold[k-1];
    end
    psc_valid_stage #(
      .KILLABLE(k < FLUSH_DEPTH)
    ) u_stg (
      .clk         (clk),
      .rst         (rst),
      .kill_i      (flush_i),
      .hold_self_i (hold[k]),
      .hold_prev_i (prev_h),
      .prev_valid_i(prev_v),
      .valid_o     (valid_o[k])
    );
  end

  assign retire_o = valid_o[LAST];

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (valid_o == '0 && !retire_o));

  p_flow_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (!dec_stall_i && !aln_stall_i && !flush_i) |=>
      (valid_o[LAST:1] == $past(valid_o[LAST-1:0]) &&
       valid_o[0] == $past(fetch_valid_i)));

  p_align_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (aln_stall_i && !flush_i) |=>
      valid_o[ALN_IDX:0] == $past(valid_o[ALN_IDX:0]));

  p_wb_drain_r5: assert property (@(posedge clk) disable iff (rst)
    aln_stall_i |=> !retire_o);

  p_dec_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_stall_i && !aln_stall_i && !flush_i) |=>
      (!valid_o[DEC_IDX+1] &&
       valid_o[DEC_IDX:0] == $past(valid_o[DEC_IDX:0])));

  p_flush_front_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> valid_o[FLUSH_DEPTH-1:0] == '0);

  p_wb_moves_r9: assert property (@(posedge clk) disable iff (rst)
    adv_o[LAST]);
endmodule

// File: tb/psc_pipe_ctl_test.sv
`timescale 1ns/1ps
module psc_pipe_ctl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fetch_valid_i = 1'b0;
  logic       dec_stall_i = 1'b0;
  logic       aln_stall_i = 1'b0;
  logic       flush_i = 1'b0;
  logic [5:0] adv_o;
  logic [5:0] valid_o;
  logic       retire_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  psc_pipe_ctl uut (
    .clk(clk), .rst(rst), .fetch_valid_i(fetch_valid_i),
    .dec_stall_i(dec_stall_i), .aln_stall_i(aln_stall_i),
    .flush_i(flush_i), .adv_o(adv_o), .valid_o(valid_o),
    .retire_o(retire_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // set inputs (we sit just after a falling edge)
  task automatic drive(input logic f, input logic d, input logic a, input logic fl);
    fetch_valid_i = f; dec_stall_i = d; aln_stall_i = a; flush_i = fl;
    #1;
  endtask

  // one rising edge, sample at the following falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic step_chk(input string req, input logic f, input logic d,
                          input logic a, input logic fl, input logic [5:0] exp_v);
    drive(f, d, a, fl);
    tick();
    chk(req, "valid", valid_o, exp_v);
    chk(req, "retire", {5'b0, retire_o}, {5'b0, exp_v[5]});
  endtask

  task automatic t_reset();
    chk("R1", "valid after reset", valid_o, 6'b000000);
    chk("R1", "retire after reset", {5'b0, retire_o}, 6'b0);
    drive(0, 0, 0, 0);
    chk("R3", "adv idle", adv_o, 6'b111111);
    chk("R9", "wb adv idle", {5'b0, adv_o[5]}, 6'b1);
  endtask

  task automatic t_flow();
    step_chk("R2", 1, 0, 0, 0, 6'b000001);
    step_chk("R2", 0, 0, 0, 0, 6'b000010);
    step_chk("R2", 1, 0, 0, 0, 6'b000101);
    step_chk("R2", 1, 0, 0, 0, 6'b001011);
    step_chk("R2", 0, 0, 0, 0, 6'b010110);
    step_chk("R2", 0, 0, 0, 0, 6'b101100);
    step_chk("R2", 0, 0, 0, 0, 6'b011000);
    step_chk("R2", 0, 0, 0, 0, 6'b110000);
    step_chk("R2", 0, 0, 0, 0, 6'b100000);
    step_chk("R2", 0, 0, 0, 0, 6'b000000);
  endtask

  task automatic t_align();
    step_chk("R2", 1, 0, 0, 0, 6'b000001);
    step_chk("R2", 0, 0, 0, 0, 6'b000010);
    step_chk("R2", 1, 0, 0, 0, 6'b000101);
    step_chk("R2", 0, 0, 0, 0, 6'b001010);
    step_chk("R2", 1, 0, 0, 0, 6'b010101);
    step_chk("R2", 0, 0, 0, 0, 6'b101010);
    drive(1, 0, 1, 0);
    chk("R4", "adv under align hold", adv_o, 6'b100000);
    step_chk("R5", 1, 0, 1, 0, 6'b001010);
    step_chk("R4", 1, 0, 1, 0, 6'b001010);
    step_chk("R4", 0, 0, 0, 0, 6'b010100);
  endtask

  task automatic t_decode();
    step_chk("R2", 1, 0, 0, 0, 6'b101001);
    step_chk("R2", 1, 0, 0, 0, 6'b010011);
    drive(0, 1, 0, 0);
    chk("R6", "adv under decode hold", adv_o, 6'b111100);
    step_chk("R6", 0, 1, 0, 0, 6'b100011);
    step_chk("R6", 1, 1, 0, 0, 6'b000011);
    step_chk("R6", 0, 0, 0, 0, 6'b000110);
  endtask

  task automatic t_both();
    drive(1, 1, 1, 0);
    chk("R7", "adv both holds", adv_o, 6'b100000);
    step_chk("R7", 1, 1, 1, 0, 6'b000110);
  endtask

  task automatic t_flush();
    step_chk("R8", 1, 0, 0, 1, 6'b001100);
    step_chk("R2", 1, 0, 0, 0, 6'b011001);
    step_chk("R2", 1, 0, 0, 0, 6'b110011);
    step_chk("R8", 1, 1, 0, 1, 6'b100000);
    step_chk("R2", 1, 0, 0, 0, 6'b000001);
    step_chk("R2", 1, 0, 0, 0, 6'b000011);
    step_chk("R2", 0, 0, 0, 0, 6'b000110);
    step_chk("R8", 1, 0, 1, 1, 6'b000100);
  endtask

  task automatic t_reset_mid();
    step_chk("R2", 1, 0, 0, 0, 6'b001001);
    drive(1, 0, 0, 0);
    rst = 1'b1;
    tick();
    chk("R1", "valid after mid reset", valid_o, 6'b000000);
    chk("R1", "retire after mid reset", {5'b0, retire_o}, 6'b0);
    rst = 1'b0;
    drive(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_flow();
    t_align();
    t_decode();
    t_both();
    t_flush();
    t_reset_mid();
    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule